// File: doc/BRIEF.md
# Quadrant-Folded Sine/Cosine Numerically Controlled Oscillator

This block is a direct digital synthesizer. On every cycle in which the sample
enable is high, a phase accumulator adds a programmable frequency word. The
sum of the accumulator and a phase-offset word is then turned into a signed
sine sample and a signed cosine sample. Phase is in binary angular measure,
so the accumulator's top bit weighs half a turn. Both the frequency word and
the offset may change between any two samples, which gives frequency-shift or
phase-shift keying.

Only the first quadrant of a sine wave is stored. The two top phase bits pick
the quadrant. The next address bits index the quarter table. The quadrant sets
whether the address is mirrored and whether the magnitude is negated. The
cosine path reads its own copy of the same table, with the quadrant advanced by
one. Table points lie at half-step phases, so a mirrored address maps onto an
exact mirror point, and no zero or peak sample is stored twice.

Top module: `nco_quad_fold`

## Requirements
- R1: While reset is held and just after it is released, `sin_o`, `cos_o` and `out_valid` are 0 and the accumulator is 0, so the first sample's phase equals the offset present with it.
- R2: The accumulator grows by `freq_word` modulo 2^ACC_W only in cycles with `smp_en` high. Cycles without enable leave it unchanged.
- R3: A sample's phase is the accumulator value before that sample's update plus `phase_ofs`, modulo 2^ACC_W.
- R4: Phase bits [ACC_W-1:ACC_W-2] select the quadrant and bits [ACC_W-3:ACC_W-2-TBL_AW] form the table address a. Entry i of the table holds round((2^(OUT_W-1)-1)·sin(π·(i+0.5)/2^(TBL_AW+1))).
- R5: The sine is negated when the quadrant's upper bit is 1 (quadrants 2 and 3).
- R6: The table is read at 2^TBL_AW-1-a instead of a when the quadrant's lower bit is 1 (quadrants 1 and 3).
- R7: The cosine equals the sine of the same sample's phase plus a quarter turn (2^(ACC_W-2)).
- R8: `out_valid` is high exactly two cycles after each cycle with `smp_en` high, and only then. The outputs hold their values while `out_valid` is low.
- R9: A new `freq_word` or `phase_ofs` takes effect on the very next enabled sample, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Produce one sample this cycle |
| freq_word | input | ACC_W (24) | Phase increment per enabled sample |
| phase_ofs | input | ACC_W (24) | Phase offset added to the accumulator |
| sin_o | output | OUT_W (12) | Signed sine sample |
| cos_o | output | OUT_W (12) | Signed cosine sample |
| out_valid | output | 1 | Sample on `sin_o`/`cos_o` is new this cycle |

## Verification
The hardest cases to reach from the ports are samples that fall exactly on the
first and last table address of each quadrant, where an off-by-one in the
mirroring or in the cosine's quadrant advance would show. Slowly swept
increments visit those points only rarely. The stimulus therefore sets a zero
increment and drives the offset to each quadrant boundary and to the phase just
below it. Random words then cover accumulator wrap-around, gaps in the enable,
and changes of increment and offset from sample to sample.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int ACC_W_DEF  = 24;
    localparam int TBL_AW_DEF = 8;
    localparam int OUT_W_DEF  = 12;
    localparam real PI_R = 3.14159265358979323846;

    typedef enum logic [1:0] {
        QD_RISE     = 2'b00,
        QD_FALL     = 2'b01,
        QD_NEG_FALL = 2'b10,
        QD_NEG_RISE = 2'b11
    } quad_e;
endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
    parameter int ACC_W = 24,
    parameter int TW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] inc,
    input  logic [ACC_W-1:0] ofs,
    output logic [TW-1:0]    ph_top,
    output logic             ph_vld
);
    localparam int SH = ACC_W - TW;

    logic [ACC_W-1:0] acc;
    logic [TW-1:0]    sum_top;

    assign sum_top = TW'((acc + ofs) >> SH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            ph_top <= '0;
            ph_vld <= 1'b0;
        end else begin
            ph_vld <= en;
            if (en) begin
                acc    <= acc + inc;
                ph_top <= sum_top;
            end
        end
    end

    // R2: accumulator frozen while no sample is requested
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc));
endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
    parameter int AW    = 8,
    parameter int OUT_W = 12
) (
    input  logic [AW-1:0]          addr,
    output logic signed [OUT_W-1:0] mag
);
    import nco_pkg::*;

    localparam int  DEPTH = 2 ** AW;
    localparam real AMP   = real'(2 ** (OUT_W - 1) - 1);

    logic signed [OUT_W-1:0] tbl [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        localparam real ANG = PI_R * (real'(gi) + 0.5) / real'(2 * DEPTH);
        localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
        assign tbl[gi] = OUT_W'(VAL);
    end

    assign mag = tbl[addr];
endmodule

// File: rtl/nco_quadrant_fold.sv
module nco_quadrant_fold #(
    parameter int AW    = 8,
    parameter int OUT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_in,
    input  logic [AW+1:0]           ph,
    output logic signed [OUT_W-1:0] sin_q,
    output logic signed [OUT_W-1:0] cos_q,
    output logic                    vld_q
);
    import nco_pkg::*;

    quad_e                   q_sin, q_cos;
    logic [AW-1:0]           a_raw, a_sin, a_cos;
    logic signed [OUT_W-1:0] m_sin, m_cos, s_next, c_next;

    always_comb begin
        q_sin = quad_e'(ph[AW+1:AW]);
        q_cos = quad_e'(ph[AW+1:AW] + 2'd1);
        a_raw = ph[AW-1:0];
        unique case (q_sin)
            QD_RISE, QD_NEG_FALL: a_sin = a_raw;
            QD_FALL, QD_NEG_RISE: a_sin = ~a_raw;
        endcase
        unique case (q_cos)
            QD_RISE, QD_NEG_FALL: a_cos = a_raw;
            QD_FALL, QD_NEG_RISE: a_cos = ~a_raw;
        endcase
    end

    nco_quarter_rom #(.AW(AW), .OUT_W(OUT_W)) u_rom_sin (.addr(a_sin), .mag(m_sin));
    nco_quarter_rom #(.AW(AW), .OUT_W(OUT_W)) u_rom_cos (.addr(a_cos), .mag(m_cos));

    always_comb begin
        s_next = q_sin[1] ? -m_sin : m_sin;
        c_next = q_cos[1] ? -m_cos : m_cos;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sin_q <= '0;
            cos_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= vld_in;
            if (vld_in) begin
                sin_q <= s_next;
                cos_q <= c_next;
            end
        end
    end

    // Every table entry is non-zero, so the sign follows the quadrant.
    always_comb begin
        if (rst_n) begin
            p_sin_sign_r5: assert (s_next[OUT_W-1] == q_sin[1]);
            p_cos_sign_r7: assert (c_next[OUT_W-1] == q_cos[1]);
            p_mirror_r6:   assert ((a_sin ^ a_cos) == {AW{1'b1}});
        end
    end
endmodule

// File: rtl/nco_quad_fold.sv
module nco_quad_fold #(
    parameter int ACC_W  = nco_pkg::ACC_W_DEF,
    parameter int TBL_AW = nco_pkg::TBL_AW_DEF,
    parameter int OUT_W  = nco_pkg::OUT_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_en,
    input  logic [ACC_W-1:0]        freq_word,
    input  logic [ACC_W-1:0]        phase_ofs,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic                    out_valid
);
    localparam int TW = TBL_AW + 2;

    logic [TW-1:0] ph_top;
    logic          ph_vld;

    nco_phase_accum #(.ACC_W(ACC_W), .TW(TW)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(smp_en),
        .inc(freq_word), .ofs(phase_ofs),
        .ph_top(ph_top), .ph_vld(ph_vld)
    );

    nco_quadrant_fold #(.AW(TBL_AW), .OUT_W(OUT_W)) u_fold (
        .clk(clk), .rst_n(rst_n), .vld_in(ph_vld), .ph(ph_top),
        .sin_q(sin_o), .cos_q(cos_o), .vld_q(out_valid)
    );

    // R8: fixed two-cycle latency, no spurious valid, hold between samples
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |-> ##2 out_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_en, 2));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(sin_o) && $stable(cos_o)));
endmodule

// File: tb/tb_nco_quad_fold.sv
`timescale 1ns/1ps
module tb_nco_quad_fold;
    localparam int  AW_ACC = 24;
    localparam int  AW_TBL = 8;
    localparam int  OW     = 12;
    localparam int  DEPTH  = 2 ** AW_TBL;
    localparam real PI_B   = 3.14159265358979323846;
    localparam real AMP_B  = real'(2 ** (OW - 1) - 1);
    localparam logic [AW_ACC-1:0] QTR = 24'h400000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic [AW_ACC-1:0] freq_word = '0;
    logic [AW_ACC-1:0] phase_ofs = '0;
    logic signed [OW-1:0] sin_o, cos_o;
    logic out_valid;

    always #2 clk = ~clk;

    nco_quad_fold dut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .freq_word(freq_word),
        .phase_ofs(phase_ofs), .sin_o(sin_o), .cos_o(cos_o), .out_valid(out_valid)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [AW_ACC-1:0] m_acc = '0;
    logic e1_v = 1'b0, e2_v = 1'b0;
    logic [AW_ACC-1:0] e1_p = '0, e2_p = '0;
    logic signed [OW-1:0] last_s = '0, last_c = '0;

    function automatic int tbl_val(input int i);
        real ang;
        ang = PI_B * (real'(i) + 0.5) / real'(2 * DEPTH);
        return $rtoi(AMP_B * $sin(ang) + 0.5);
    endfunction

    function automatic logic signed [OW-1:0] ref_sin(input logic [AW_ACC-1:0] p);
        logic [1:0] q;
        int a, v;
        q = p[AW_ACC-1:AW_ACC-2];
        a = int'(p[AW_ACC-3:AW_ACC-2-AW_TBL]);
        if (q[0]) a = DEPTH - 1 - a;     // R6 mirror
        v = tbl_val(a);                  // R4 table
        if (q[1]) v = -v;                // R5 negate
        return OW'(v);
    endfunction

    function automatic string sin_tag(input logic [AW_ACC-1:0] p);
        case (p[AW_ACC-1:AW_ACC-2])
            2'b00: return "R4";
            2'b01: return "R6";
            2'b10: return "R5";
            default: return "R5/R6";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic check_outputs();
        logic signed [OW-1:0] es, ec;
        n_chk++;
        if (out_valid !== e2_v) begin
            n_err++;
            $display("FAIL R8 valid: got %0b expected %0b", out_valid, e2_v);
        end
        if (e2_v) begin
            es = ref_sin(e2_p);
            ec = ref_sin(e2_p + QTR);    // R7 cosine = sine a quarter turn on
            n_chk++;
            if (sin_o !== es) begin
                n_err++;
                $display("FAIL %s sine phase %h: got %0d expected %0d",
                         sin_tag(e2_p), e2_p, sin_o, es);
            end
            n_chk++;
            if (cos_o !== ec) begin
                n_err++;
                $display("FAIL R7 cosine phase %h: got %0d expected %0d", e2_p, cos_o, ec);
            end
            last_s = es;
            last_c = ec;
        end else begin
            n_chk++;
            if (sin_o !== last_s || cos_o !== last_c) begin
                n_err++;
                $display("FAIL R8 hold: got %0d/%0d expected %0d/%0d",
                         sin_o, cos_o, last_s, last_c);
            end
        end
    endtask

    // R2 R3 R9: model accumulator updated on every enabled sample
    task automatic step(input logic en, input logic [AW_ACC-1:0] inc,
                        input logic [AW_ACC-1:0] ofs);
        @(negedge clk);
        check_outputs();
        e2_v = e1_v;
        e2_p = e1_p;
        smp_en = en;
        freq_word = inc;
        phase_ofs = ofs;
        e1_v = en;
        e1_p = m_acc + ofs;
        if (en) m_acc = m_acc + inc;
    endtask

    initial begin
        #(4ns * 200000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            smp_en = 1'b1;
            freq_word = 24'h123456;
            n_chk++;
            if (sin_o !== 0 || cos_o !== 0 || out_valid !== 1'b0) begin
                n_err++;
                $display("FAIL R1 reset: got %0d/%0d/%0b expected 0/0/0",
                         sin_o, cos_o, out_valid);
            end
        end
        smp_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first sample after reset sits at the offset alone
        step(1'b1, 24'h0ABCDE, 24'h000000);
        step(1'b1, 24'h0ABCDE, 24'h000000);
        step(1'b0, 24'h0, 24'h0);
        // quadrant boundaries with zero increment: R4 R5 R6 R7
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 24'h0, QTR * k - m_acc);
            step(1'b1, 24'h0, QTR * (k + 1) - 24'h1 - m_acc);
            step(1'b0, 24'h0, 24'h0);
        end
        // R2: idle gaps leave the accumulator alone
        step(1'b1, 24'h100000, 24'h0);
        for (int i = 0; i < 5; i++) step(1'b0, 24'hFFFFFF, 24'h0);
        step(1'b1, 24'h100000, 24'h0);
        // R9: increment and offset change every sample (keying)
        for (int i = 0; i < 16; i++)
            step(1'b1, (i % 2) ? 24'h080000 : 24'h010000, (i % 3 == 0) ? 24'h800000 : 24'h0);
        // wrap-around of the accumulator: R2
        for (int i = 0; i < 40; i++) step(1'b1, 24'hF00001, 24'h0);
        // random mix: R2 R3 R8 R9
        for (int i = 0; i < 4000; i++) begin
            logic [AW_ACC-1:0] r_inc, r_ofs;
            r_inc = 24'($urandom);
            r_ofs = ($urandom_range(0, 3) == 0) ? 24'($urandom) : 24'h0;
            step(($urandom_range(0, 3) != 0), r_inc, r_ofs);
        end
        step(1'b0, 24'h0, 24'h0);
        step(1'b0, 24'h0, 24'h0);
        step(1'b0, 24'h0, 24'h0);
        finish_run();
    end
endmodule